// File: doc/BRIEF.md
# Serial-Load Latched Output Driver

This block is the logic core of a cascadable driver with twenty on/off outputs, meant for display segments, digits or dots. A host supplies three serial lines: data, a shift clock and an enable envelope. While the envelope is high, each rising edge of the shift clock moves one bit into a shift register. When the envelope drops, the whole register is copied into an output latch. The outputs only take on the new pattern at that moment. During the transfer they keep showing the previous one.

A separate blanking line turns every output off without touching the stored pattern. A cascade output presents the bit leaving the end of the register. It changes on the falling edge of the shift clock, so a second driver wired to it can sample it on the next rising edge. Several drivers can then share one data stream.

The serial lines are asynchronous to the fast system clock that runs the block. Each line is resynchronized through a flop chain. The shift-clock and enable edges are then found by comparing the synchronized level with its value one system cycle earlier. The serial clock never clocks any flop.

Top module: `serial_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the output latch, `drive_o` and `cascade_o` to zero.
- R2: On a rising shift-clock edge while enable is high, the register takes in the data bit. After exactly NUM_OUT such edges, the first bit sent sits in the stage that drives `drive_o[0]`, and the last bit sent sits in the stage that drives `drive_o[NUM_OUT-1]`.
- R3: While enable is high, `drive_o` keeps the previously latched pattern no matter how many bits are shifted.
- R4: A 1-to-0 change of enable copies the register into the latch. `drive_o` then shows it, with a 1 meaning on and a 0 meaning off, 4 system cycles after the input change.
- R5: Shift-clock edges while enable is low change neither the stored register nor `cascade_o`. A later enable pulse with no shift-clock edges re-presents the unchanged register on `drive_o`.
- R6: When more than NUM_OUT bits are sent in one envelope, only the last NUM_OUT bits are kept. The earliest of those bits drives `drive_o[0]`.
- R7: While `blank_i` is 1, `drive_o` is all zeros, 3 system cycles after `blank_i` rises, whatever the state of enable. Loading still proceeds while blanked. When `blank_i` returns to 0, the latched pattern reappears.
- R8: On a falling shift-clock edge while enable is high, `cascade_o` takes the value of the stage that drives `drive_o[0]`. It updates 3 system cycles after the input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data, sampled on the shift clock's rising edge |
| load_en_i | input | 1 | Enable envelope; a falling edge loads the latch |
| blank_i | input | 1 | 1 forces all outputs off |
| drive_o | output | NUM_OUT | Registered output enables, 1 = on |
| cascade_o | output | 1 | Serial output toward a downstream driver |

## Verification
Every serial input passes through two synchronizer flops before the block acts on it. A shift or a cascade update therefore lands on the third system edge after the input change. A blank takes effect on `drive_o` at the third edge. A latch load shows on `drive_o` at the fourth edge, because the latch and the output register are both in the path. The bench holds each serial level for four system cycles. It reads `cascade_o` four cycles after every falling shift edge and reads `drive_o` eight cycles after an enable fall or a blank change. Each sample therefore falls after the due cycle and before the next stimulus can act. The bench also checks the held pattern on every bit of every frame, so a latch that loads early shows up at once.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned SLD_OUTPUTS = 20;
  localparam int unsigned SLD_SYNC    = 2;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
  parameter int unsigned N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         din_i,
  input  logic         casc_i,
  output logic [N-1:0] sr_o,
  output logic         casc_o
);
  // The newest bit enters at the top; the oldest bit reaches index 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_o   <= '0;
      casc_o <= 1'b0;
    end else begin
      if (shift_i) sr_o <= {din_i, sr_o[N-1:1]};
      if (casc_i)  casc_o <= sr_o[0];
    end
  end
endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage #(
  parameter int unsigned N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         blank_i,
  input  logic [N-1:0] sr_i,
  output logic [N-1:0] latch_o,
  output logic [N-1:0] drive_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_o <= '0;
      drive_o <= '0;
    end else begin
      if (load_i) latch_o <= sr_i;
      drive_o <= blank_i ? '0 : latch_o;
    end
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int unsigned NUM_OUT     = SLD_OUTPUTS,
  parameter int unsigned SYNC_STAGES = SLD_SYNC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               load_en_i,
  input  logic               blank_i,
  output logic [NUM_OUT-1:0] drive_o,
  output logic               cascade_o
);
  localparam int unsigned SYNC_W = 4;

  logic [SYNC_W-1:0] raw_in, synced;
  logic clk_s, data_s, en_s, blank_s;
  logic clk_d, en_d;
  logic shift_pulse, casc_pulse, load_pulse;
  logic [NUM_OUT-1:0] sr_q, latch_q;

  assign raw_in = {blank_i, load_en_i, ser_data_i, ser_clk_i};

  sld_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (synced)
  );

  assign {blank_s, en_s, data_s, clk_s} = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      clk_d <= clk_s;
      en_d  <= en_s;
    end
  end

  assign shift_pulse = clk_s & ~clk_d & en_s;
  assign casc_pulse  = ~clk_s & clk_d & en_s;
  assign load_pulse  = ~en_s & en_d;

  sld_shift_chain #(.N(NUM_OUT)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_i (shift_pulse),
    .din_i   (data_s),
    .casc_i  (casc_pulse),
    .sr_o    (sr_q),
    .casc_o  (cascade_o)
  );

  sld_out_stage #(.N(NUM_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_pulse),
    .blank_i (blank_s),
    .sr_i    (sr_q),
    .latch_o (latch_q),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int unsigned N = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_pulse,
  input logic         casc_pulse,
  input logic         load_pulse,
  input logic         blank_s,
  input logic [N-1:0] sr_q,
  input logic [N-1:0] latch_q,
  input logic [N-1:0] drive_o,
  input logic         cascade_o
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> sr_q[N-2:0] == $past(sr_q[N-1:1])); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_pulse |=> $stable(latch_q)); // R3
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> latch_q == $past(sr_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_pulse |=> $stable(sr_q)); // R5
  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (rst)
    blank_s |=> drive_o == '0); // R7
  AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !casc_pulse |=> $stable(cascade_o)); // R8
endmodule

bind serial_latch_driver sld_checker #(.N(NUM_OUT)) u_sld_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_pulse (shift_pulse),
  .casc_pulse  (casc_pulse),
  .load_pulse  (load_pulse),
  .blank_s     (blank_s),
  .sr_q        (sr_q),
  .latch_q     (latch_q),
  .drive_o     (drive_o),
  .cascade_o   (cascade_o)
);

// File: tb/serial_latch_driver_bench.sv
module serial_latch_driver_bench;
  localparam int N  = 20;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, load_en = 1'b0, blank = 1'b0;
  logic [N-1:0] drive;
  logic cascade;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [N-1:0] m_sr  = '0;
  logic [N-1:0] m_lat = '0;
  logic         m_casc = 1'b0;
  logic [31:0]  seed = 32'h1234_5679;

  always #2.5 clk = ~clk;

  serial_latch_driver #(.NUM_OUT(N)) u_serial_latch_driver (
    .clk        (clk),
    .rst        (rst),
    .ser_clk_i  (ser_clk),
    .ser_data_i (ser_data),
    .load_en_i  (load_en),
    .blank_i    (blank),
    .drive_o    (drive),
    .cascade_o  (cascade)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s drive act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cascade act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_drive();
    return blank ? '0 : m_lat;
  endfunction

  // One shift-clock period; with enable high the model shifts (R2) and
  // the cascade output follows stage 0 after the falling edge (R8).
  task automatic ser_bit(input logic b);
    ser_data = b;
    wait_cyc(PH);
    ser_clk = 1'b1;
    wait_cyc(PH);
    ser_clk = 1'b0;
    wait_cyc(PH);
    if (load_en) begin
      m_sr   = {b, m_sr[N-1:1]};
      m_casc = m_sr[0];
    end
    chk_bit("R8", cascade, m_casc);
    chk_vec("R3", drive, exp_drive());
  endtask

  // Sends len bits, bit 0 of stream first, inside one enable envelope.
  task automatic send_stream(input logic [63:0] stream, input int len, input string req);
    load_en = 1'b1;
    wait_cyc(PH);
    for (int i = 0; i < len; i++) ser_bit(stream[i]);
    load_en = 1'b0;
    wait_cyc(8);
    m_lat = m_sr;
    chk_vec(req, drive, exp_drive());
  endtask

  function automatic logic [N-1:0] next_word();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[N-1:0];
  endfunction

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    // R1: reset state
    chk_vec("R1", drive, '0);
    chk_bit("R1", cascade, 1'b0);

    // R2/R4: walking one, then walking zero, over every output
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] w;
      w = '0;
      w[k] = 1'b1;
      send_stream({44'd0, w}, N, "R4");
      chk_vec("R2", drive, w);
    end
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] w;
      w = '1;
      w[k] = 1'b0;
      send_stream({44'd0, w}, N, "R4");
      chk_vec("R2", drive, w);
    end
    send_stream({44'd0, {N{1'b1}}}, N, "R4");

    // R2/R4: pseudo-random words
    for (int t = 0; t < 30; t++) begin
      logic [N-1:0] w;
      w = next_word();
      send_stream({44'd0, w}, N, "R4");
      chk_vec("R2", drive, w);
    end

    // R6: overlong frames keep the last N bits
    for (int extra = 1; extra <= 8; extra += 3) begin
      logic [63:0] s;
      s = {next_word(), next_word(), next_word(), 4'h0};
      send_stream(s, N + extra, "R6");
      chk_vec("R6", drive, s[extra +: N]);
    end

    // R5: shift-clock edges with enable low change nothing
    begin
      logic [N-1:0] held;
      held = m_sr;
      for (int i = 0; i < 6; i++) ser_bit(i[0]);
      chk_vec("R5", drive, m_lat);
      chk_bit("R5", cascade, m_casc);
      load_en = 1'b1;
      wait_cyc(8);
      load_en = 1'b0;
      wait_cyc(8);
      chk_vec("R5", drive, held);
      m_lat = m_sr;
    end

    // R7: blank forces off, loading continues, pattern returns
    blank = 1'b1;
    wait_cyc(8);
    chk_vec("R7", drive, '0);
    begin
      logic [N-1:0] w;
      w = next_word() | 20'h1;
      send_stream({44'd0, w}, N, "R7");
      chk_vec("R7", drive, '0);
      blank = 1'b0;
      wait_cyc(8);
      chk_vec("R7", drive, w);
      // blank while enable high, independent of the envelope
      load_en = 1'b1;
      wait_cyc(PH);
      blank = 1'b1;
      wait_cyc(8);
      chk_vec("R7", drive, '0);
      blank = 1'b0;
      wait_cyc(8);
      chk_vec("R7", drive, w);
      load_en = 1'b0;
      wait_cyc(8);
      chk_vec("R4", drive, w);
    end

    // R1: reset in mid-operation
    send_stream({44'd0, 20'hA5C3F}, N, "R4");
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(2);
    m_sr = '0; m_lat = '0; m_casc = 1'b0;
    chk_vec("R1", drive, '0);
    chk_bit("R1", cascade, 1'b0);
    load_en = 1'b1;
    wait_cyc(8);
    load_en = 1'b0;
    wait_cyc(8);
    chk_vec("R1", drive, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule